// File: doc/BRIEF.md
# USB Host Transmit Endpoint Controller

This block holds the 8-bit control and status register of one host-side transmit endpoint and the logic that sequences it. A CPU writes the register to commit packets, to choose a SETUP or OUT token, to clear the data toggle, to discard a packet and to acknowledge status. The CPU reads back the live register value at any time. A transaction engine sees a request line together with the token type and the data toggle. For every attempt it returns one handshake result: ACK, NAK, STALL or timeout.

The block counts the packets held in a transmit FIFO of parameterised depth (two by default, which gives double buffering). It keeps the data toggle, a consecutive-NAK counter that is compared against a limit input, and a counter of attempts that ended with no handshake. A STALL, a NAK timeout or three silent attempts halt the endpoint until software clears the matching status bit. One-cycle pulses tell the FIFO to drop its newest packet or to drop all packets, tell the DMA engine to abort, and raise an interrupt.

Top module: `usb_txep_ctrl`

## Requirements
- R1: After reset the register reads 0x00, `txn_req`, `txn_setup` and `txn_toggle` are 0, and no pulse output is high. Register bit positions: 7 NAK-timeout, 6 clear-toggle, 5 stall-received, 4 setup-token, 3 flush, 2 error, 1 not-empty, 0 packet-ready.
- R2: A write with bit 0 set commits one packet, but only when the FIFO holds fewer than FIFO_DEPTH packets and no STALL is taken in the same cycle. A commit to a full FIFO is ignored. Bit 1 reads 1 while at least one packet is held. Bit 0 reads 1 only while FIFO_DEPTH packets are held, so with depth 2 it drops back to 0 after the first commit.
- R3: An accepted ACK (hs_code 0) removes one packet, inverts the data toggle, clears the setup-token bit and resets both the NAK and the retry counters.
- R4: With a non-zero `nak_limit`, the accepted NAK (hs_code 1) that brings the consecutive-NAK count up to the limit sets bit 7 and restarts the count. A limit of 0 never sets bit 7.
- R5: The third accepted timeout (hs_code 3) without an ACK in between sets bit 2.
- R6: An accepted STALL (hs_code 2) sets bit 5, empties the FIFO and pulses `dma_abort` and `fifo_flush_all` for one cycle.
- R7: Bits 7, 5 and 2 are cleared by writing 0 to them. Writing 1 to them leaves them unchanged.
- R8: `txn_req` is high exactly when at least one packet is held and none of bits 7, 5, 2 is set. A handshake that arrives while `txn_req` is low has no effect.
- R9: A committing write that also sets bit 4 sets the setup-token bit (`txn_setup`) and clears the toggle. Bit 4 written without a commit is ignored.
- R10: Writing 1 to bit 6 clears the toggle. Bits 6 and 3 always read 0.
- R11: Writing 1 to bit 3 removes the newest packet (if one is held), clears the setup-token bit and pulses `fifo_flush_last` and `irq`.
- R12: `irq` pulses for one cycle when bit 7, 5 or 2 goes from 0 to 1, in the same cycle as the new bit value becomes readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Register write strobe |
| cpu_wdata | input | 8 | Register write data |
| cpu_rdata | output | 8 | Live register value |
| nak_limit | input | NAK_W | Consecutive NAK limit, 0 disables |
| txn_req | output | 1 | Transaction request |
| txn_setup | output | 1 | 1 selects a SETUP token, 0 an OUT token |
| txn_toggle | output | 1 | Data toggle for the next packet |
| hs_valid | input | 1 | Handshake result valid |
| hs_code | input | 2 | 0 ACK, 1 NAK, 2 STALL, 3 timeout |
| fifo_flush_last | output | 1 | Pulse: drop the newest FIFO packet |
| fifo_flush_all | output | 1 | Pulse: drop every FIFO packet |
| dma_abort | output | 1 | Pulse: abort the DMA request |
| irq | output | 1 | Interrupt pulse |

## Verification
The hardest state to reach is a halt that arrives part-way through a sequence, such as a NAK timeout while a SETUP packet waits in a half-full buffer with the retry counter already advanced. The stimulus mixes random writes, with the status-clear bits biased towards 1 so that halts persist, with random handshake codes weighted towards NAK and timeout. It changes `nak_limit` now and then and also offers handshakes while the request is low. Directed sequences before the random phase cover the three-timeout error, a STALL on a full FIFO, and a commit to a full FIFO.

// File: rtl/usb_txep_pkg.sv
package usb_txep_pkg;
   typedef enum logic [1:0] {
      HS_ACK   = 2'd0,
      HS_NAK   = 2'd1,
      HS_STALL = 2'd2,
      HS_TMO   = 2'd3
   } hs_e;

   localparam int B_NAKTO  = 7;
   localparam int B_CLRTOG = 6;
   localparam int B_STALL  = 5;
   localparam int B_SETUP  = 4;
   localparam int B_FLUSH  = 3;
   localparam int B_ERR    = 2;
   localparam int B_NEMPTY = 1;
   localparam int B_READY  = 0;
endpackage

// File: rtl/txep_occupancy.sv
module txep_occupancy #(
   parameter int DEPTH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic inc,
   input  logic pop,
   input  logic drop_one,
   input  logic drop_all,
   output logic full,
   output logic not_empty
);
   localparam int CW = $clog2(DEPTH + 1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("txep_occupancy: DEPTH must be at least 1");
   end

   if (DEPTH == 1) begin : g_flag
      logic occ;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        occ <= 1'b0;
         else if (drop_all) occ <= 1'b0;
         else               occ <= (occ | inc) & ~(pop | drop_one);
      end
      assign full      = occ;
      assign not_empty = occ;
   end else begin : g_count
      logic [CW-1:0] cnt;
      logic [CW:0]   up;
      logic [CW:0]   dn;
      always_comb begin
         up = {1'b0, cnt} + {{CW{1'b0}}, inc};
         dn = {{CW{1'b0}}, pop} + {{CW{1'b0}}, drop_one};
      end
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        cnt <= '0;
         else if (drop_all) cnt <= '0;
         else if (up < dn)  cnt <= '0;
         else               cnt <= CW'(up - dn);
      end
      assign full      = (cnt == CW'(DEPTH));
      assign not_empty = (cnt != '0);
   end
endmodule

// File: rtl/txep_hs_track.sv
module txep_hs_track
   import usb_txep_pkg::*;
#(
   parameter int NAK_W     = 8,
   parameter int RETRY_MAX = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             take,
   input  hs_e              code,
   input  logic [NAK_W-1:0] nak_limit,
   output logic             ack_ev,
   output logic             stall_ev,
   output logic             nak_hit,
   output logic             err_hit
);
   localparam int RW = (RETRY_MAX > 1) ? $clog2(RETRY_MAX) : 1;

   if (RETRY_MAX < 1) begin : g_bad_retry
      $error("txep_hs_track: RETRY_MAX must be at least 1");
   end

   logic [NAK_W-1:0] nak_cnt;
   logic [RW-1:0]    retry_cnt;
   logic             nak_ev;
   logic             tmo_ev;
   logic [NAK_W:0]   nak_next;

   always_comb begin
      ack_ev   = take && (code == HS_ACK);
      nak_ev   = take && (code == HS_NAK);
      stall_ev = take && (code == HS_STALL);
      tmo_ev   = take && (code == HS_TMO);
      nak_next = {1'b0, nak_cnt} + 1'b1;
      nak_hit  = nak_ev && (nak_limit != '0) && (nak_next >= {1'b0, nak_limit});
      err_hit  = tmo_ev && (retry_cnt == RW'(RETRY_MAX - 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nak_cnt   <= '0;
         retry_cnt <= '0;
      end else begin
         if (ack_ev || stall_ev || nak_hit)        nak_cnt <= '0;
         else if (nak_ev && (nak_limit != '0))     nak_cnt <= nak_next[NAK_W-1:0];

         if (ack_ev || stall_ev || err_hit)        retry_cnt <= '0;
         else if (tmo_ev)                          retry_cnt <= retry_cnt + 1'b1;
      end
   end
endmodule

// File: rtl/usb_txep_ctrl.sv
module usb_txep_ctrl
   import usb_txep_pkg::*;
#(
   parameter int FIFO_DEPTH = 2,
   parameter int NAK_W      = 8,
   parameter int RETRY_MAX  = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cpu_wr,
   input  logic [7:0]       cpu_wdata,
   output logic [7:0]       cpu_rdata,
   input  logic [NAK_W-1:0] nak_limit,
   output logic             txn_req,
   output logic             txn_setup,
   output logic             txn_toggle,
   input  logic             hs_valid,
   input  logic [1:0]       hs_code,
   output logic             fifo_flush_last,
   output logic             fifo_flush_all,
   output logic             dma_abort,
   output logic             irq
);
   if (NAK_W < 1) begin : g_bad_nakw
      $error("usb_txep_ctrl: NAK_W must be at least 1");
   end

   logic naktmout_q, rxstall_q, error_q, setup_q, toggle_q;
   logic full, not_empty, halted, take;
   logic ack_ev, stall_ev, nak_hit, err_hit;
   logic flush_wr, commit_ok, setup_set, tog_clr;
   logic irq_n;

   assign halted  = naktmout_q | rxstall_q | error_q;
   assign txn_req = not_empty & ~halted;
   assign take    = hs_valid & txn_req;

   txep_hs_track #(.NAK_W(NAK_W), .RETRY_MAX(RETRY_MAX)) u_hs (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .code      (hs_e'(hs_code)),
      .nak_limit (nak_limit),
      .ack_ev    (ack_ev),
      .stall_ev  (stall_ev),
      .nak_hit   (nak_hit),
      .err_hit   (err_hit)
   );

   always_comb begin
      flush_wr  = cpu_wr & cpu_wdata[B_FLUSH];
      commit_ok = cpu_wr & cpu_wdata[B_READY] & ~full & ~stall_ev;
      setup_set = commit_ok & cpu_wdata[B_SETUP];
      tog_clr   = (cpu_wr & cpu_wdata[B_CLRTOG]) | setup_set;
      irq_n     = (nak_hit & ~naktmout_q) | (stall_ev & ~rxstall_q)
                | (err_hit & ~error_q) | flush_wr;
   end

   txep_occupancy #(.DEPTH(FIFO_DEPTH)) u_occ (
      .clk       (clk),
      .rst_n     (rst_n),
      .inc       (commit_ok),
      .pop       (ack_ev),
      .drop_one  (flush_wr),
      .drop_all  (stall_ev),
      .full      (full),
      .not_empty (not_empty)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         naktmout_q      <= 1'b0;
         rxstall_q       <= 1'b0;
         error_q         <= 1'b0;
         setup_q         <= 1'b0;
         toggle_q        <= 1'b0;
         irq             <= 1'b0;
         fifo_flush_last <= 1'b0;
         fifo_flush_all  <= 1'b0;
         dma_abort       <= 1'b0;
      end else begin
         if (nak_hit)                              naktmout_q <= 1'b1;
         else if (cpu_wr && !cpu_wdata[B_NAKTO])   naktmout_q <= 1'b0;

         if (stall_ev)                             rxstall_q <= 1'b1;
         else if (cpu_wr && !cpu_wdata[B_STALL])   rxstall_q <= 1'b0;

         if (err_hit)                              error_q <= 1'b1;
         else if (cpu_wr && !cpu_wdata[B_ERR])     error_q <= 1'b0;

         if (setup_set)                            setup_q <= 1'b1;
         else if (ack_ev || stall_ev || flush_wr)  setup_q <= 1'b0;

         if (tog_clr)                              toggle_q <= 1'b0;
         else if (ack_ev)                          toggle_q <= ~toggle_q;

         irq             <= irq_n;
         fifo_flush_last <= flush_wr;
         fifo_flush_all  <= stall_ev;
         dma_abort       <= stall_ev;
      end
   end

   always_comb begin
      cpu_rdata           = '0;
      cpu_rdata[B_NAKTO]  = naktmout_q;
      cpu_rdata[B_STALL]  = rxstall_q;
      cpu_rdata[B_SETUP]  = setup_q;
      cpu_rdata[B_ERR]    = error_q;
      cpu_rdata[B_NEMPTY] = not_empty;
      cpu_rdata[B_READY]  = full;
   end

   assign txn_setup  = setup_q;
   assign txn_toggle = toggle_q;
endmodule

// File: rtl/usb_txep_ctrl_chk.sv
module usb_txep_ctrl_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       cpu_wr,
   input logic [7:0] cpu_wdata,
   input logic [7:0] cpu_rdata,
   input logic       txn_req,
   input logic       txn_toggle,
   input logic       hs_valid,
   input logic [1:0] hs_code,
   input logic       fifo_flush_last,
   input logic       fifo_flush_all,
   input logic       dma_abort,
   input logic       irq
);
   a_r8_no_req_halted: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_rdata[7] || cpu_rdata[5] || cpu_rdata[2]) |-> !txn_req);

   a_r2_ready_implies_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_rdata[0] |-> cpu_rdata[1]);

   a_r6_stall_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && txn_req && hs_code == 2'd2) |=>
         (cpu_rdata[5] && !cpu_rdata[1] && !cpu_rdata[0] && dma_abort && fifo_flush_all));

   a_r3_ack_flips_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_valid && txn_req && hs_code == 2'd0 && !cpu_wr) |=> (txn_toggle != $past(txn_toggle)));

   a_r11_flush_pulses: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_wr && cpu_wdata[3]) |=> (fifo_flush_last && irq));

   a_r12_irq_on_error: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cpu_rdata[2]) |-> irq);
endmodule

bind usb_txep_ctrl usb_txep_ctrl_chk u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .cpu_wr          (cpu_wr),
   .cpu_wdata       (cpu_wdata),
   .cpu_rdata       (cpu_rdata),
   .txn_req         (txn_req),
   .txn_toggle      (txn_toggle),
   .hs_valid        (hs_valid),
   .hs_code         (hs_code),
   .fifo_flush_last (fifo_flush_last),
   .fifo_flush_all  (fifo_flush_all),
   .dma_abort       (dma_abort),
   .irq             (irq)
);

// File: tb/usb_txep_ctrl_tb.sv
`timescale 1ns/1ps
module usb_txep_ctrl_tb;
   localparam int DEPTH = 2;
   localparam int NW    = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_wr = 1'b0;
   logic [7:0]    cpu_wdata = '0;
   logic [7:0]    cpu_rdata;
   logic [NW-1:0] nak_limit = '0;
   logic          txn_req, txn_setup, txn_toggle;
   logic          hs_valid = 1'b0;
   logic [1:0]    hs_code = '0;
   logic          fifo_flush_last, fifo_flush_all, dma_abort, irq;

   int errors = 0;
   int checks = 0;
   bit done = 0;

   always #4 clk = ~clk;

   usb_txep_ctrl #(.FIFO_DEPTH(DEPTH), .NAK_W(NW), .RETRY_MAX(3)) u_dut (
      .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .nak_limit(nak_limit), .txn_req(txn_req),
      .txn_setup(txn_setup), .txn_toggle(txn_toggle), .hs_valid(hs_valid),
      .hs_code(hs_code), .fifo_flush_last(fifo_flush_last),
      .fifo_flush_all(fifo_flush_all), .dma_abort(dma_abort), .irq(irq)
   );

   // bench reference state
   int m_cnt, m_nakc, m_retry;
   bit m_nto, m_stl, m_err, m_setup, m_tog;
   bit e_irq, e_fl, e_fa;

   task automatic chk(input string tag, input int got, input int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   function automatic bit m_req();
      return (m_cnt != 0) && !(m_nto || m_stl || m_err);
   endfunction

   function automatic logic [7:0] m_reg();
      return {m_nto, 1'b0, m_stl, m_setup, 1'b0, m_err, (m_cnt != 0), (m_cnt == DEPTH)};
   endfunction

   task automatic model(input bit wr, input logic [7:0] wd, input bit hv,
                        input logic [1:0] hc, input int lim);
      bit take, ack, stall, nhit, ehit, flush, commit;
      int n;
      take  = hv && m_req();
      ack   = take && hc == 2'd0;
      stall = take && hc == 2'd2;
      nhit  = 0;
      ehit  = 0;
      if (take && hc == 2'd1 && lim != 0) begin
         if (m_nakc + 1 >= lim) begin nhit = 1; m_nakc = 0; end
         else m_nakc++;
      end
      if (take && hc == 2'd3) begin
         if (m_retry + 1 == 3) begin ehit = 1; m_retry = 0; end
         else m_retry++;
      end
      if (ack || stall) begin m_nakc = 0; m_retry = 0; end
      flush  = wr && wd[3];
      commit = wr && wd[0] && (m_cnt < DEPTH) && !stall;
      e_irq  = (nhit && !m_nto) || (stall && !m_stl) || (ehit && !m_err) || flush;
      e_fl   = flush;
      e_fa   = stall;
      if (stall) m_cnt = 0;
      else begin
         n = m_cnt + int'(commit) - int'(ack) - int'(flush);
         m_cnt = (n < 0) ? 0 : n;
      end
      if (nhit) m_nto = 1; else if (wr && !wd[7]) m_nto = 0;
      if (stall) m_stl = 1; else if (wr && !wd[5]) m_stl = 0;
      if (ehit) m_err = 1; else if (wr && !wd[2]) m_err = 0;
      if (commit && wd[4]) m_setup = 1; else if (ack || stall || flush) m_setup = 0;
      if ((wr && wd[6]) || (commit && wd[4])) m_tog = 0; else if (ack) m_tog = ~m_tog;
   endtask

   task automatic compare();
      chk("R2 ready/notempty", int'(cpu_rdata[1:0]), int'(m_reg() & 8'h03));
      chk("R4 naktimeout", int'(cpu_rdata[7]), int'(m_nto));
      chk("R5 error", int'(cpu_rdata[2]), int'(m_err));
      chk("R6 stall bit", int'(cpu_rdata[5]), int'(m_stl));
      chk("R6 flush_all", int'(fifo_flush_all), int'(e_fa));
      chk("R6 dma_abort", int'(dma_abort), int'(e_fa));
      chk("R9 setup bit", int'(cpu_rdata[4]), int'(m_setup));
      chk("R9 txn_setup", int'(txn_setup), int'(m_setup));
      chk("R10 strobes read 0", int'({cpu_rdata[6], cpu_rdata[3]}), 0);
      chk("R3 toggle", int'(txn_toggle), int'(m_tog));
      chk("R8 txn_req", int'(txn_req), int'(m_req()));
      chk("R11 flush_last", int'(fifo_flush_last), int'(e_fl));
      chk("R12 irq", int'(irq), int'(e_irq));
   endtask

   task automatic step(input bit wr, input logic [7:0] wd, input bit hv, input logic [1:0] hc);
      @(negedge clk);
      cpu_wr = wr; cpu_wdata = wd; hs_valid = hv; hs_code = hc;
      @(posedge clk);
      model(wr, wd, hv, hc, int'(nak_limit));
      #1;
      compare();
   endtask

   task automatic set_limit(input int lim);
      @(negedge clk);
      cpu_wr = 0; hs_valid = 0; nak_limit = NW'(lim);
      @(posedge clk);
      model(0, 8'h00, 0, 2'd0, lim);
      #1;
      compare();
   endtask

   initial begin
      #(8 * 200000);
      errors++;
      $display("FAIL watchdog: got 1 expected 0");
      if (!done) begin
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [7:0] wd;
      int r;
      void'($urandom(32'd20240611));
      m_cnt = 0; m_nakc = 0; m_retry = 0;
      m_nto = 0; m_stl = 0; m_err = 0; m_setup = 0; m_tog = 0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1 reset reg", int'(cpu_rdata), 0);
      chk("R1 reset outputs", int'({txn_req, txn_setup, txn_toggle, irq,
                                    fifo_flush_last, fifo_flush_all, dma_abort}), 0);
      @(negedge clk); rst_n = 1;
      #1;
      // R2: double buffer ready behaviour, full commit ignored
      step(1, 8'hA5, 0, 0);
      chk("R2 after first commit", int'(cpu_rdata[1:0]), 2);
      step(1, 8'hA5, 0, 0);
      chk("R2 full", int'(cpu_rdata[1:0]), 3);
      step(1, 8'hA5, 0, 0);
      // R3: ACK removes a packet and flips the toggle
      step(0, 0, 1, 2'd0);
      chk("R3 toggle after ack", int'(txn_toggle), 1);
      // R5: three timeouts
      step(0, 0, 1, 2'd3); step(0, 0, 1, 2'd3); step(0, 0, 1, 2'd3);
      chk("R5 error set", int'(cpu_rdata[2]), 1);
      step(0, 0, 1, 2'd0);
      chk("R8 ack ignored when halted", int'(cpu_rdata[1]), 1);
      step(1, 8'hA0, 0, 0);
      chk("R7 error cleared", int'(cpu_rdata[2]), 0);
      // R9: setup commit, R6: stall on full FIFO
      step(1, 8'hB5, 0, 0);
      chk("R9 setup token", int'(txn_setup), 1);
      step(0, 0, 1, 2'd2);
      chk("R6 stall empties", int'(cpu_rdata[1]), 0);
      step(1, 8'h84, 0, 0);
      // R4: NAK limit 2
      set_limit(2);
      step(1, 8'hA5, 0, 0);
      step(0, 0, 1, 2'd1); step(0, 0, 1, 2'd1);
      chk("R4 nak timeout", int'(cpu_rdata[7]), 1);
      step(1, 8'h2C, 0, 0);
      // R10/R11 via random phase
      for (int i = 0; i < 6000; i++) begin
         r = int'($urandom % 16);
         if (r < 5) begin
            wd = 8'($urandom);
            if (($urandom % 4) != 0) wd = wd | 8'hA4;
            step(1, wd, 0, 0);
         end else if (r < 14) begin
            r = int'($urandom % 8);
            step(0, 0, 1, (r < 2) ? 2'd0 : (r < 5) ? 2'd1 : (r < 6) ? 2'd2 : 2'd3);
         end else if (r == 14) begin
            set_limit(int'($urandom % 6));
         end else begin
            step(0, 0, 0, 0);
         end
      end
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule